// File: doc/BRIEF.md
# Power-Good Strap Latch and Power-Down Sequencer

This block serves the combined power-good / power-down input of a clock generator. After reset it waits with its strap latches open and its clock outputs gated. The first time the synchronized pin is seen high, it captures the three frequency-select straps and a small group of mode straps. It does this once and moves to the running state. From then on the straps are ignored, except while a test-mode input is held. In test mode the latched values follow the straps on every running cycle.

After the capture the same pin works as an active-low power-down request. The pin passes through a two-flop synchronizer before any logic sees it. When a power-down arrives, one of two things happens:

- If the restore bit and the management-mode bit are both clear, the block raises a one-cycle configuration-clear pulse and drops its latches. It then returns to the latches-open state, which mimics a cold start.
- Otherwise it keeps its configuration and enters power-down. It gates the outputs first and only one cycle later drops the oscillator/PLL enable. On wake-up the enable returns at once, and the outputs stay gated until a programmable lock-delay count runs out.

Top module: `pgood_pd_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `state_o` is 0 (latches open), `fsel_q` and `mode_q` are 0, `out_en` is 0 and `osc_pll_en` is 1.
- R2: The pin is seen only through a two-flop synchronizer. A level change that is driven before clock edge k changes `state_o` no earlier than edge k+2.
- R3: In the latches-open state, the first synchronized high level moves `state_o` to 1 (run) and captures `fsel_strap` and `mode_strap` into `fsel_q` and `mode_q` on the same edge.
- R4: After the capture, with `test_en` low, changes on `fsel_strap` and `mode_strap` leave `fsel_q` and `mode_q` unchanged.
- R5: With `test_en` high in the run state, `fsel_q` and `mode_q` load the strap inputs on every clock edge.
- R6: In the run state, if a synchronized low is seen with `restore_cfg`=0 and `mgmt_mode`=0, `cfg_clear` is 1 for exactly that cycle. On the next edge `state_o` returns to 0 and the latched straps are cleared to 0.
- R7: If the same low is seen with `restore_cfg`=1 or `mgmt_mode`=1, `cfg_clear` stays 0, `state_o` becomes 2 (power-down) and the latched straps are kept.
- R8: On entry to power-down, `out_en` goes to 0 one cycle before `osc_pll_en` goes to 0.
- R9: In power-down, a synchronized high sets `osc_pll_en` to 1 at once. `out_en` then stays 0 for `lock_delay`+1 further cycles before `state_o` returns to 1 and `out_en` to 1.
- R10: `fsel_rsvd` is 1 exactly when `fsel_q` holds the reserved code 3'b111.
- R11: `state_o` uses 0 for latches open, 1 for run and 2 for every power-down phase, including the wake-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 1 | Asynchronous power-good / power-down pin |
| fsel_strap | input | 3 | Frequency-select straps, bit 2 is the most significant |
| mode_strap | input | MODE_W (2) | Mode straps |
| test_en | input | 1 | Test mode: the strap latch tracks its inputs while running |
| restore_cfg | input | 1 | 1 = keep the configuration across power-down |
| mgmt_mode | input | 1 | 1 = power-down never clears the configuration |
| lock_delay | input | CNT_W (4) | Lock-wait cycles minus one before the outputs are re-enabled |
| fsel_q | output | 3 | Latched frequency select |
| mode_q | output | MODE_W (2) | Latched mode straps |
| fsel_rsvd | output | 1 | Latched frequency code is reserved |
| cfg_clear | output | 1 | One-cycle configuration-clear pulse |
| out_en | output | 1 | Clock output enable |
| osc_pll_en | output | 1 | Oscillator and PLL enable |
| state_o | output | 2 | Externally visible state |

## Verification
The bench builds the block with its defaults: a 2-flop synchronizer, 2 mode strap bits and a 4-bit lock counter. With these values every frequency-select code can be paired with every combination of the restore and management bits in one compact sweep. Lock delays of 0 to 3 are cycled across that sweep. This covers the cold-start path, the keep path, the reserved code and the zero-delay wake-up. A separate test-mode pass checks that the strap latch tracks its inputs while the test input is held and freezes once it is released.

// File: rtl/pgood_pd_pkg.sv
// Shared types and constants for the power-good / power-down controller.
// Assumes a single reference clock domain for all internal state.
package pgood_pd_pkg;

    localparam int FSEL_W = 3;
    localparam logic [FSEL_W-1:0] FSEL_RESERVED = 3'b111;

    // Internal sequencer states; several map onto one external code.
    typedef enum logic [2:0] {
        ST_OPEN    = 3'd0,
        ST_RUN     = 3'd1,
        ST_PD_GATE = 3'd2,
        ST_PD      = 3'd3,
        ST_WAKE    = 3'd4
    } pd_state_e;

    localparam logic [1:0] VIS_OPEN = 2'd0;
    localparam logic [1:0] VIS_RUN  = 2'd1;
    localparam logic [1:0] VIS_PD   = 2'd2;

endpackage

// File: rtl/pd_pin_sync.sv
// Multi-flop synchronizer for the asynchronous power-good / power-down pin.
// Assumes STAGES >= 2; the flops reset to 0, which reads as "not powered good".
module pd_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] sh_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_async};
    end

    assign q_sync = sh_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (q_sync == $past(d_async, 2))) // R2
                else $error("synchronizer latency broken");
        end
    endgenerate

endmodule

// File: rtl/strap_hold.sv
// Strap latch: loads the frequency-select and mode straps when told to.
// A clear has priority over a load. Assumes the strap inputs are quasi-static.
module strap_hold #(
    parameter int FW = 3,
    parameter int MW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          track,
    input  logic          clear,
    input  logic [FW-1:0] fsel_in,
    input  logic [MW-1:0] mode_in,
    output logic [FW-1:0] fsel_q,
    output logic [MW-1:0] mode_q
);

    // Hold, load or clear the latched strap values.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fsel_q <= '0;
            mode_q <= '0;
        end else if (capture || track) begin
            fsel_q <= fsel_in;
            mode_q <= mode_in;
        end
    end

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clear) |=> (fsel_q == $past(fsel_in) && mode_q == $past(mode_in))) // R3
        else $error("capture did not load straps");

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !track && !clear) |=> ($stable(fsel_q) && $stable(mode_q))) // R4
        else $error("latched straps moved without a load");

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fsel_q == '0 && mode_q == '0)) // R6
        else $error("clear did not zero latch");

endmodule

// File: rtl/pd_seq_fsm.sv
// Power sequencer: one-shot strap capture, then power-down handling through
// the synchronized pin. Power-down gates the outputs before the oscillator and
// PLL are disabled. Wake-up waits lock_delay+1 cycles before enabling outputs.
module pd_seq_fsm
    import pgood_pd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_s,
    input  logic             test_en,
    input  logic             restore_cfg,
    input  logic             mgmt_mode,
    input  logic [CNT_W-1:0] lock_delay,
    output logic             capture_o,
    output logic             track_o,
    output logic             clear_o,
    output logic             out_en_o,
    output logic             osc_pll_en_o,
    output logic [1:0]       state_o
);

    pd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             keep_cfg;

    assign keep_cfg = restore_cfg || mgmt_mode;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OPEN:    if (pin_s) state_d = ST_RUN;
            ST_RUN:     if (!pin_s) state_d = keep_cfg ? ST_PD_GATE : ST_OPEN;
            ST_PD_GATE: state_d = ST_PD;
            ST_PD:      if (pin_s) state_d = ST_WAKE;
            ST_WAKE:    if (!pin_s) state_d = ST_PD;
                        else if (cnt_q == '0) state_d = ST_RUN;
            default:    state_d = ST_OPEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Lock-wait counter: loaded on wake entry, counts down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt_q <= '0;
        else if (state_q == ST_PD && pin_s)         cnt_q <= lock_delay;
        else if (state_q == ST_WAKE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Output decode.
    always_comb begin
        capture_o    = (state_q == ST_OPEN) && pin_s;
        track_o      = (state_q == ST_RUN) && test_en;
        clear_o      = (state_q == ST_RUN) && !pin_s && !keep_cfg;
        out_en_o     = (state_q == ST_RUN);
        osc_pll_en_o = (state_q != ST_PD);
        case (state_q)
            ST_OPEN: state_o = VIS_OPEN;
            ST_RUN:  state_o = VIS_RUN;
            default: state_o = VIS_PD;
        endcase
    end

    AST_GATE_BEFORE_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_pll_en_o) |-> $past(!out_en_o)) // R8
        else $error("oscillator dropped while outputs were enabled");

    AST_CLEAR_TO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (state_q == ST_OPEN)) // R6
        else $error("clear did not return to latches open");

    AST_KEEP_CFG_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !pin_s && keep_cfg) |=> (state_q == ST_PD_GATE && !clear_o)) // R7
        else $error("kept-configuration power-down misrouted");

    AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && cnt_q != '0 && pin_s) |=> (state_q == ST_WAKE)) // R9
        else $error("left lock wait early");

    AST_WAKE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && cnt_q == '0 && pin_s) |=> out_en_o) // R9
        else $error("outputs not enabled after lock wait");

endmodule

// File: rtl/pgood_pd_ctrl.sv
// Top level: synchronizer, sequencer and strap latch for the dual-function
// power-good / power-down pin. Assumes every input except pin_raw is synchronous to clk.
module pgood_pd_ctrl
    import pgood_pd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MODE_W      = 2,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_raw,
    input  logic [FSEL_W-1:0] fsel_strap,
    input  logic [MODE_W-1:0] mode_strap,
    input  logic              test_en,
    input  logic              restore_cfg,
    input  logic              mgmt_mode,
    input  logic [CNT_W-1:0]  lock_delay,
    output logic [FSEL_W-1:0] fsel_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              fsel_rsvd,
    output logic              cfg_clear,
    output logic              out_en,
    output logic              osc_pll_en,
    output logic [1:0]        state_o
);

    logic pin_s;
    logic capture, track;

    pd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (pin_s)
    );

    pd_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_s        (pin_s),
        .test_en      (test_en),
        .restore_cfg  (restore_cfg),
        .mgmt_mode    (mgmt_mode),
        .lock_delay   (lock_delay),
        .capture_o    (capture),
        .track_o      (track),
        .clear_o      (cfg_clear),
        .out_en_o     (out_en),
        .osc_pll_en_o (osc_pll_en),
        .state_o      (state_o)
    );

    strap_hold #(.FW(FSEL_W), .MW(MODE_W)) u_straps (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .track   (track),
        .clear   (cfg_clear),
        .fsel_in (fsel_strap),
        .mode_in (mode_strap),
        .fsel_q  (fsel_q),
        .mode_q  (mode_q)
    );

    // Flag the reserved frequency-select code.
    assign fsel_rsvd = (fsel_q == FSEL_RESERVED);

    AST_PD_KEEPS_STRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == VIS_PD && !track) |=> $stable(fsel_q)) // R7
        else $error("straps changed during power-down");

endmodule

// File: tb/pgood_pd_ctrl_bench.sv
// Sweep bench: every frequency code crossed with every restore/management
// combination, plus a test-mode pass. All drives are applied on the falling edge.
module pgood_pd_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0;
    logic [2:0] fsel_strap = '0;
    logic [1:0] mode_strap = '0;
    logic       test_en = 1'b0;
    logic       restore_cfg = 1'b0;
    logic       mgmt_mode = 1'b0;
    logic [3:0] lock_delay = '0;
    logic [2:0] fsel_q;
    logic [1:0] mode_q;
    logic       fsel_rsvd, cfg_clear, out_en, osc_pll_en;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pgood_pd_ctrl u_pgood_pd_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .fsel_strap(fsel_strap),
        .mode_strap(mode_strap), .test_en(test_en), .restore_cfg(restore_cfg),
        .mgmt_mode(mgmt_mode), .lock_delay(lock_delay), .fsel_q(fsel_q),
        .mode_q(mode_q), .fsel_rsvd(fsel_rsvd), .cfg_clear(cfg_clear),
        .out_en(out_en), .osc_pll_en(osc_pll_en), .state_o(state_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pin_raw = 1'b0; test_en = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int code = 0; code < 8; code++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                automatic logic [1:0] mval = 2'(code + cfg);
                automatic int         lat = (code + cfg) % 4;
                automatic bit         cold = (cfg == 0);
                restore_cfg = cfg[0];
                mgmt_mode = cfg[1];
                lock_delay = 4'(lat);
                do_reset();
                // R1 reset state
                check("R1 state", state_o, 0);
                check("R1 fsel", fsel_q, 0);
                check("R1 out_en", out_en, 0);
                check("R1 osc", osc_pll_en, 1);
                fsel_strap = 3'(code);
                mode_strap = mval;
                tick(2);
                check("R3 waits open", state_o, 0);
                pin_raw = 1'b1;
                tick(2);
                check("R2 sync latency", state_o, 0);
                tick(1);
                check("R3 R11 run", state_o, 1);
                check("R3 fsel", fsel_q, code);
                check("R3 mode", mode_q, mval);
                check("R10 rsvd", fsel_rsvd, (code == 7) ? 1 : 0);
                check("R3 out_en", out_en, 1);
                fsel_strap = ~3'(code);
                mode_strap = ~mval;
                tick(3);
                check("R4 fsel ignored", fsel_q, code);
                check("R4 mode ignored", mode_q, mval);
                pin_raw = 1'b0;
                tick(2);
                check("R6 R7 clear pulse", cfg_clear, cold ? 1 : 0);
                check("R2 still run", state_o, 1);
                tick(1);
                check("R6 R7 no clear now", cfg_clear, 0);
                if (cold) begin
                    check("R6 open", state_o, 0);
                    check("R6 fsel zero", fsel_q, 0);
                    check("R6 mode zero", mode_q, 0);
                    pin_raw = 1'b1;
                    tick(3);
                    check("R6 recapture", fsel_q, 7 - code);
                    check("R6 run", state_o, 1);
                end else begin
                    check("R7 R11 pd", state_o, 2);
                    check("R8 gated", out_en, 0);
                    check("R8 osc still on", osc_pll_en, 1);
                    tick(1);
                    check("R8 osc off", osc_pll_en, 0);
                    check("R7 kept", fsel_q, code);
                    pin_raw = 1'b1;
                    tick(3);
                    check("R9 R11 wake", state_o, 2);
                    check("R9 osc on", osc_pll_en, 1);
                    check("R9 out off", out_en, 0);
                    if (lat > 0) begin
                        tick(lat);
                        check("R9 still locking", out_en, 0);
                    end
                    tick(1);
                    check("R9 out on", out_en, 1);
                    check("R9 run", state_o, 1);
                    check("R7 kept after wake", fsel_q, code);
                    check("R7 mode kept", mode_q, mval);
                end
            end
        end
        // R5 test-mode tracking
        restore_cfg = 1'b1; mgmt_mode = 1'b0;
        do_reset();
        fsel_strap = 3'd2; mode_strap = 2'd1;
        pin_raw = 1'b1;
        tick(3);
        check("R3 test base", fsel_q, 2);
        test_en = 1'b1;
        for (int v = 0; v < 8; v++) begin
            fsel_strap = 3'(v);
            mode_strap = 2'(v);
            tick(1);
            check("R5 track fsel", fsel_q, v);
            check("R5 track mode", mode_q, v % 4);
            check("R10 rsvd track", fsel_rsvd, (v == 7) ? 1 : 0);
        end
        test_en = 1'b0;
        fsel_strap = 3'd5;
        tick(2);
        check("R4 frozen after test", fsel_q, 7);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule